// File: doc/BRIEF.md
# Bidirectional Dual FIFO with Mailboxes

This block joins two clocked ports with two FIFOs that carry data in opposite directions. Port A writes the first FIFO and Port B drains it. Port B writes the second FIFO and Port A drains it. Each FIFO holds 256 words of 36 bits by default. Each direction also has a single-word mailbox with a full flag. A mailbox suits short control messages that should bypass the queued traffic.

Each port qualifies every access with an enable, a request, a read/write line and a resource select, all sampled on the rising clock edge. Both ports run on one clock, so the block is a fully synchronous model. Full and empty flags for each FIFO are registered and derived from an occupancy count. A write to a full FIFO is dropped, and so is a read from an empty FIFO.

Top module: `bidir_fifo_pair`

## Requirements
- R1: Words written by Port A come out at Port B in write order, and words written by Port B come out at Port A in write order. Each FIFO holds DEPTH words of DATA_W bits.
- R2: A FIFO write happens on a rising edge only when enable=1, request=1, rd=0 and the select addresses the FIFO (Port A select 3'b111, Port B select 1). If any of these is missing, neither FIFO nor mailbox state changes.
- R3: A FIFO read takes the same qualifiers with rd=1. If any is missing, the port's read data and the FIFO's flags stay unchanged.
- R4: The full flag is 1 once DEPTH words are held. A write to a full FIFO is dropped. The full flag clears at the edge of the first read from a full FIFO.
- R5: A read from an empty FIFO is dropped, and the port's read data output keeps its previous value.
- R6: While rst_ni is low, both empty flags are 1, both full flags and both mailbox flags are 0, and both read data outputs are 0. After reset, the first word written is the first word read.
- R7: A mailbox write (Port A select 3'b110, Port B select 0) stores the word and sets that direction's mailbox flag. A mailbox read from the opposite port returns the word and clears the flag.
- R8: A mailbox write while its flag is set is dropped, and the stored word is kept.
- R9: A read and a write to the same FIFO in one cycle, with the FIFO neither empty nor full, both complete and leave its flags unchanged. When the FIFO is full, the read completes, the write is dropped and the full flag clears.
- R10: Flags and read data are registered. They change at the same rising edge that accepts the access.
- R11: Port A select codes 3'b000 to 3'b101 address nothing. Accesses with these codes change no flag and no read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by both ports |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_en_i | input | 1 | Port A enable |
| a_req_i | input | 1 | Port A request |
| a_rd_i | input | 1 | Port A direction: 1 = read, 0 = write |
| a_sel_i | input | 3 | Port A resource select |
| a_wdata_i | input | DATA_W | Port A write data |
| a_rdata_o | output | DATA_W | Port A registered read data |
| b_en_i | input | 1 | Port B enable |
| b_req_i | input | 1 | Port B request |
| b_rd_i | input | 1 | Port B direction: 1 = read, 0 = write |
| b_sel_i | input | 1 | Port B select: 1 = FIFO, 0 = mailbox |
| b_wdata_i | input | DATA_W | Port B write data |
| b_rdata_o | output | DATA_W | Port B registered read data |
| ab_full_o | output | 1 | A-to-B FIFO full |
| ab_empty_o | output | 1 | A-to-B FIFO empty |
| ba_full_o | output | 1 | B-to-A FIFO full |
| ba_empty_o | output | 1 | B-to-A FIFO empty |
| ab_mbox_full_o | output | 1 | A-to-B mailbox holds an unread word |
| ba_mbox_full_o | output | 1 | B-to-A mailbox holds an unread word |

## Verification
The assertions assume that rst_ni is low from time zero and that every qualifier and select input has a known value at each rising edge. They also assume the caller may issue accesses that are dropped, such as a write to a full FIFO, a read from an empty one or an unused select code, so the properties cover dropped accesses as well as accepted ones. The stimulus changes inputs one time unit after the active edge and returns both ports to idle after each access. It sweeps every combination of missing qualifiers and every unused select code on an empty block. It also fills the FIFOs to the exact full boundary and overlaps reads with writes while a FIFO is full and while it is partly filled.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
  typedef struct packed {
    logic fifo_wr;
    logic fifo_rd;
    logic mb_wr;
    logic mb_rd;
  } acc_t;

  localparam logic [2:0] A_SEL_FIFO = 3'b111;
  localparam logic [2:0] A_SEL_MBOX = 3'b110;
  localparam logic [0:0] B_SEL_FIFO = 1'b1;
  localparam logic [0:0] B_SEL_MBOX = 1'b0;
endpackage

// File: rtl/bfp_decode.sv
module bfp_decode
  import bfp_pkg::*;
#(
  parameter int unsigned      SEL_W     = 1,
  parameter logic [SEL_W-1:0] FIFO_CODE = '1,
  parameter logic [SEL_W-1:0] MBOX_CODE = '0
) (
  input  logic             en_i,
  input  logic             req_i,
  input  logic             rd_i,
  input  logic [SEL_W-1:0] sel_i,
  output acc_t             acc_o
);
  logic go;

  always_comb begin
    go           = en_i & req_i;
    acc_o.fifo_wr = go & ~rd_i & (sel_i == FIFO_CODE);
    acc_o.fifo_rd = go &  rd_i & (sel_i == FIFO_CODE);
    acc_o.mb_wr   = go & ~rd_i & (sel_i == MBOX_CODE);
    acc_o.mb_rd   = go &  rd_i & (sel_i == MBOX_CODE);
  end
endmodule

// File: rtl/bfp_fifo.sv
module bfp_fifo #(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned DEPTH  = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic              rd_fire_o,
  output logic [DATA_W-1:0] head_o,
  output logic              full_o,
  output logic              empty_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wptr_q, rptr_q;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              full_q, empty_q;
  logic              wr_ok, rd_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wr_ok = wr_i & ~full_q;
    rd_ok = rd_i & ~empty_q;
    cnt_d = cnt_q;
    if (wr_ok && !rd_ok)      cnt_d = cnt_q + CW'(1);
    else if (rd_ok && !wr_ok) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      if (wr_ok) wptr_q <= bump(wptr_q);
      if (rd_ok) rptr_q <= bump(rptr_q);
      cnt_q   <= cnt_d;
      full_q  <= (cnt_d == CW'(DEPTH));
      empty_q <= (cnt_d == '0);
    end
  end

  // storage carries no reset
  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[wptr_q] <= wdata_i;
  end

  assign head_o    = mem_q[rptr_q];
  assign rd_fire_o = rd_ok;
  assign full_o    = full_q;
  assign empty_o   = empty_q;

  p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  p_full_block_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && wr_i && !rd_i) |=> (full_q && $stable(wptr_q)));
  p_empty_block_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_q && rd_i && !wr_i) |=> (empty_q && $stable(rptr_q)));
  p_both_steady_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && rd_i && !full_q && !empty_q) |=> $stable(cnt_q));
  p_flag_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_q && empty_q));
  p_full_track_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q == (cnt_q == CW'(DEPTH)));
endmodule

// File: rtl/bfp_mbox.sv
module bfp_mbox #(
  parameter int unsigned DATA_W = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o
);
  logic [DATA_W-1:0] data_q;
  logic              full_q;
  logic              wr_ok;

  assign wr_ok = wr_i & ~full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (wr_ok) begin
        data_q <= wdata_i;
        full_q <= 1'b1;
      end else if (rd_i) begin
        full_q <= 1'b0;
      end
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;

  p_mb_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !full_q) |=> full_q);
  p_mb_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i) |=> !full_q);
  p_mb_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && wr_i) |=> $stable(data_q));
endmodule

// File: rtl/bidir_fifo_pair.sv
module bidir_fifo_pair
  import bfp_pkg::*;
#(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned DEPTH  = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_en_i,
  input  logic              a_req_i,
  input  logic              a_rd_i,
  input  logic [2:0]        a_sel_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  output logic [DATA_W-1:0] a_rdata_o,
  input  logic              b_en_i,
  input  logic              b_req_i,
  input  logic              b_rd_i,
  input  logic [0:0]        b_sel_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  output logic [DATA_W-1:0] b_rdata_o,
  output logic              ab_full_o,
  output logic              ab_empty_o,
  output logic              ba_full_o,
  output logic              ba_empty_o,
  output logic              ab_mbox_full_o,
  output logic              ba_mbox_full_o
);
  localparam int unsigned NDIR = 2;

  // index 0: written by A, read by B; index 1: written by B, read by A
  acc_t              acc     [NDIR];
  logic [DATA_W-1:0] wdata   [NDIR];
  logic [DATA_W-1:0] head    [NDIR];
  logic [DATA_W-1:0] mb_data [NDIR];
  logic [DATA_W-1:0] rdata_q [NDIR];
  logic              rd_fire [NDIR];
  logic              f_full  [NDIR];
  logic              f_empty [NDIR];
  logic              mb_full [NDIR];

  assign wdata[0] = a_wdata_i;
  assign wdata[1] = b_wdata_i;

  bfp_decode #(.SEL_W(3), .FIFO_CODE(A_SEL_FIFO), .MBOX_CODE(A_SEL_MBOX)) u_dec_a (
    .en_i(a_en_i), .req_i(a_req_i), .rd_i(a_rd_i), .sel_i(a_sel_i), .acc_o(acc[0])
  );
  bfp_decode #(.SEL_W(1), .FIFO_CODE(B_SEL_FIFO), .MBOX_CODE(B_SEL_MBOX)) u_dec_b (
    .en_i(b_en_i), .req_i(b_req_i), .rd_i(b_rd_i), .sel_i(b_sel_i), .acc_o(acc[1])
  );

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    localparam int unsigned RD = NDIR - 1 - d;

    bfp_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (acc[d].fifo_wr),
      .wdata_i  (wdata[d]),
      .rd_i     (acc[RD].fifo_rd),
      .rd_fire_o(rd_fire[d]),
      .head_o   (head[d]),
      .full_o   (f_full[d]),
      .empty_o  (f_empty[d])
    );

    bfp_mbox #(.DATA_W(DATA_W)) u_mbox (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (acc[d].mb_wr),
      .wdata_i(wdata[d]),
      .rd_i   (acc[RD].mb_rd),
      .data_o (mb_data[d]),
      .full_o (mb_full[d])
    );

    // read data register of the port that drains direction d
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              rdata_q[RD] <= '0;
      else if (rd_fire[d])      rdata_q[RD] <= head[d];
      else if (acc[RD].mb_rd)   rdata_q[RD] <= mb_data[d];
    end

    p_rdata_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!rd_fire[d] && !acc[RD].mb_rd) |=> $stable(rdata_q[RD]));
    p_mb_return_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc[RD].mb_rd && !acc[RD].fifo_rd) |=> (rdata_q[RD] == $past(mb_data[d])));
  end

  assign a_rdata_o      = rdata_q[0];
  assign b_rdata_o      = rdata_q[1];
  assign ab_full_o      = f_full[0];
  assign ab_empty_o     = f_empty[0];
  assign ba_full_o      = f_full[1];
  assign ba_empty_o     = f_empty[1];
  assign ab_mbox_full_o = mb_full[0];
  assign ba_mbox_full_o = mb_full[1];
endmodule

// File: tb/sim_bidir_fifo_pair.sv
module sim_bidir_fifo_pair;
  localparam int W = 36;
  localparam int D = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_en = 0, a_req = 0, a_rd = 0;
  logic [2:0] a_sel = '0;
  logic [W-1:0] a_wd = '0;
  logic b_en = 0, b_req = 0, b_rd = 0;
  logic [0:0] b_sel = '0;
  logic [W-1:0] b_wd = '0;
  logic [W-1:0] a_rdata, b_rdata;
  logic ab_full, ab_empty, ba_full, ba_empty, ab_mb, ba_mb;

  int total = 0;
  int bad = 0;
  logic [W-1:0] q [$];
  logic [W-1:0] held;

  always #5 clk = ~clk;

  bidir_fifo_pair #(.DATA_W(W), .DEPTH(D)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .a_en_i(a_en), .a_req_i(a_req), .a_rd_i(a_rd), .a_sel_i(a_sel),
    .a_wdata_i(a_wd), .a_rdata_o(a_rdata),
    .b_en_i(b_en), .b_req_i(b_req), .b_rd_i(b_rd), .b_sel_i(b_sel),
    .b_wdata_i(b_wd), .b_rdata_o(b_rdata),
    .ab_full_o(ab_full), .ab_empty_o(ab_empty),
    .ba_full_o(ba_full), .ba_empty_o(ba_empty),
    .ab_mbox_full_o(ab_mb), .ba_mbox_full_o(ba_mb)
  );

  function automatic logic [W-1:0] pat(int i, int s);
    return {4'(s), 32'(i * 32'h9E37_79B1 + 17)};
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    a_en = 0; a_req = 0; a_rd = 0; a_sel = '0; a_wd = '0;
    b_en = 0; b_req = 0; b_rd = 0; b_sel = '0; b_wd = '0;
  endtask

  task automatic set_a(logic en, logic req, logic rd, logic [2:0] sel, logic [W-1:0] d);
    a_en = en; a_req = req; a_rd = rd; a_sel = sel; a_wd = d;
  endtask

  task automatic set_b(logic en, logic req, logic rd, logic sel, logic [W-1:0] d);
    b_en = en; b_req = req; b_rd = rd; b_sel = sel; b_wd = d;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    idle();
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1;
    // R6 reset state
    chk("R6 ab_empty", W'(ab_empty), W'(1));
    chk("R6 ba_empty", W'(ba_empty), W'(1));
    chk("R6 ab_full", W'(ab_full), W'(0));
    chk("R6 ba_full", W'(ba_full), W'(0));
    chk("R6 mbox flags", W'({ab_mb, ba_mb}), W'(0));
    chk("R6 a_rdata", a_rdata, '0);
    chk("R6 b_rdata", b_rdata, '0);
    rst_n = 1'b1;
    tick();

    // R2 missing qualifiers on Port A
    for (int m = 0; m < 15; m++) begin
      set_a(m[0], m[1], ~m[2], m[3] ? 3'b111 : 3'(m % 6), pat(m, 9));
      tick();
      chk("R2 A qual ab_empty", W'(ab_empty), W'(1));
      chk("R2 A qual ab_mb", W'(ab_mb), W'(0));
    end
    // R2 missing qualifiers on Port B
    for (int m = 0; m < 7; m++) begin
      set_b(m[0], m[1], ~m[2], 1'b1, pat(m, 8));
      tick();
      chk("R2 B qual ba_empty", W'(ba_empty), W'(1));
    end
    // R11 unused Port A codes
    for (int c = 0; c < 6; c++) begin
      set_a(1, 1, 0, 3'(c), pat(c, 7));
      tick();
      chk("R11 write code", W'({ab_empty, ab_mb, ab_full}), W'(3'b100));
      held = a_rdata;
      set_a(1, 1, 1, 3'(c), '0);
      tick();
      chk("R11 read code", a_rdata, held);
    end

    // R3 read qualifiers, one word in B->A FIFO
    set_b(1, 1, 0, 1'b1, pat(0, 2));
    tick();
    chk("R10 ba_empty after write", W'(ba_empty), W'(0));
    held = a_rdata;
    for (int m = 0; m < 7; m++) begin
      set_a(m[0], m[1], 1'b1, m[2] ? 3'b111 : 3'(m % 6), '0);
      tick();
      chk("R3 qual a_rdata", a_rdata, held);
      chk("R3 qual ba_empty", W'(ba_empty), W'(0));
    end
    set_a(1, 1, 1, 3'b111, '0);
    tick();
    chk("R3 read data", a_rdata, pat(0, 2));
    chk("R10 ba_empty after read", W'(ba_empty), W'(1));

    // R7 / R8 mailboxes
    set_a(1, 1, 0, 3'b110, pat(1, 5));
    tick();
    chk("R7 ab_mb set", W'(ab_mb), W'(1));
    chk("R7 fifo untouched", W'(ab_empty), W'(1));
    set_a(1, 1, 0, 3'b110, pat(2, 5));
    tick();
    chk("R8 ab_mb still set", W'(ab_mb), W'(1));
    set_b(1, 1, 1, 1'b0, '0);
    tick();
    chk("R8 kept word", b_rdata, pat(1, 5));
    chk("R7 ab_mb clear", W'(ab_mb), W'(0));
    set_b(1, 1, 0, 1'b0, pat(3, 5));
    tick();
    chk("R7 ba_mb set", W'(ba_mb), W'(1));
    set_a(1, 1, 1, 3'b110, '0);
    tick();
    chk("R7 a mailbox word", a_rdata, pat(3, 5));
    chk("R7 ba_mb clear", W'(ba_mb), W'(0));

    // R1 / R4 fill A->B to full
    for (int i = 0; i < D; i++) begin
      set_a(1, 1, 0, 3'b111, pat(i, 1));
      tick();
      if (i == D - 2) chk("R4 not full at D-1", W'(ab_full), W'(0));
    end
    chk("R4 full at D", W'(ab_full), W'(1));
    set_a(1, 1, 0, 3'b111, pat(999, 1));
    tick();
    chk("R4 full after dropped write", W'(ab_full), W'(1));
    set_b(1, 1, 1, 1'b1, '0);
    tick();
    chk("R1 first word", b_rdata, pat(0, 1));
    chk("R4 full clears", W'(ab_full), W'(0));
    for (int i = 1; i < D; i++) begin
      set_b(1, 1, 1, 1'b1, '0);
      tick();
      chk("R1 A->B order", b_rdata, pat(i, 1));
    end
    chk("R4 empty after drain", W'(ab_empty), W'(1));
    set_b(1, 1, 1, 1'b1, '0);
    tick();
    chk("R5 empty read holds", b_rdata, pat(D - 1, 1));

    // R1 B->A order
    for (int i = 0; i < 40; i++) begin
      set_b(1, 1, 0, 1'b1, pat(i, 3));
      tick();
    end
    for (int i = 0; i < 40; i++) begin
      set_a(1, 1, 1, 3'b111, '0);
      tick();
      chk("R1 B->A order", a_rdata, pat(i, 3));
    end
    set_a(1, 1, 1, 3'b111, '0);
    tick();
    chk("R5 empty read holds A", a_rdata, pat(39, 3));
    chk("R5 ba_empty", W'(ba_empty), W'(1));

    // R9 simultaneous read and write, partly filled
    for (int i = 0; i < 3; i++) begin
      set_a(1, 1, 0, 3'b111, pat(i, 4));
      q.push_back(pat(i, 4));
      tick();
    end
    for (int i = 3; i < 9; i++) begin
      set_a(1, 1, 0, 3'b111, pat(i, 4));
      set_b(1, 1, 1, 1'b1, '0);
      q.push_back(pat(i, 4));
      tick();
      chk("R9 both data", b_rdata, q.pop_front());
      chk("R9 flags steady", W'({ab_full, ab_empty}), W'(0));
    end
    while (q.size() > 0) begin
      set_b(1, 1, 1, 1'b1, '0);
      tick();
      chk("R9 drain", b_rdata, q.pop_front());
    end
    chk("R9 empty at end", W'(ab_empty), W'(1));

    // R9 simultaneous access on a full FIFO
    for (int i = 0; i < D; i++) begin
      set_a(1, 1, 0, 3'b111, pat(i, 6));
      tick();
    end
    set_a(1, 1, 0, 3'b111, pat(777, 6));
    set_b(1, 1, 1, 1'b1, '0);
    tick();
    chk("R9 full read", b_rdata, pat(0, 6));
    chk("R9 full clears", W'(ab_full), W'(0));
    for (int i = 1; i < D; i++) begin
      set_b(1, 1, 1, 1'b1, '0);
      tick();
      chk("R9 full drain", b_rdata, pat(i, 6));
    end
    chk("R9 dropped write absent", W'(ab_empty), W'(1));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule